// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory operation into a stream of per-element memory requests. A single start pulse hands it a base address, a byte stride, an element width code, an element count and an addressing mode; the block then emits one request per element, in ascending element order, each tagged with its byte address, its width code and its element number. Three addressing modes share the same datapath: contiguous elements, a constant byte stride, and a gather/scatter form that adds a per-element byte offset taken from an incoming index stream.

Requests leave under a valid/ready handshake, and indices arrive under a second valid/ready handshake. With the memory side ready and indices available, the block sustains one request per clock. A one-cycle done pulse marks the end of each operation. Moving the data itself is left to the surrounding load/store unit.

Top module: `vec_addr_gen`

## Requirements
- R1: Mode code 0 (and the unused code 3) is contiguous: element i goes to base + i × B, where B is the element size in bytes.
- R2: Mode code 1 is strided: element i goes to base + i × stride, with the stride a two's-complement byte distance sampled at start; addresses wrap modulo 2^ADDR_W, and a stride of zero repeats the base address.
- R3: Mode code 2 is indexed: each request's address is base + the index value presented with it (a byte offset, not scaled), and an index is consumed exactly when its request is accepted.
- R4: An operation issues exactly as many requests as the element count sampled at start, numbered 0 upward with no gaps or repeats.
- R5: Width code 0, 1, 2, 3 means 1, 2, 4, 8 bytes; every request carries the code sampled at start on its size output.
- R6: While a request is valid and not accepted, it stays valid with unchanged address and element number.
- R7: An element count of zero issues no request and raises done in the cycle after start is sampled.
- R8: Done is high for one cycle, in the cycle after the last request is accepted.
- R9: In indexed mode no request is valid while no index is valid; a missing index stalls the stream.
- R10: A start pulse while an operation is in progress is ignored and leaves that operation's stream unchanged.
- R11: The first request is valid in the cycle after start is sampled, and with the memory side always ready and indices always available an operation of N elements raises done N+1 cycles after start is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| mode | input | 2 | Addressing mode code |
| width | input | 2 | Element width code |
| base_addr | input | ADDR_W | Base byte address |
| stride | input | ADDR_W | Signed byte stride for strided mode |
| vlen | input | VL_W | Element count, 0 to MAX_VL |
| idx_valid | input | 1 | Index value present |
| idx_data | input | ADDR_W | Byte offset for the current indexed element |
| idx_ready | output | 1 | Index accepted this cycle when valid is also high |
| req_valid | output | 1 | Memory request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Byte address of the request |
| req_size | output | 2 | Width code of the request |
| req_elem | output | VL_W | Element number of the request |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench targets a zero element count (a wrong design would emit a stray request or never finish), a zero and a negative stride (a wrong design would advance by element size or lose the sign), and addresses that wrap past the top of the address space. It stalls the memory side and withholds indices at irregular points, where a broken design would advance its address while stalled, drop or duplicate an element, or issue an indexed request without an index. It also sends a second start mid-operation, which a careless design would take as a restart, and it runs the full maximum count to catch a counter that ends one element early or late.

// File: rtl/vag_pkg.sv
// Shared encodings for the vector address sequencer.
// Assumes width codes 0..3 map to 1, 2, 4, 8 byte elements.
package vag_pkg;
    typedef enum logic [1:0] {
        AM_UNIT   = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2,
        AM_RSVD   = 2'd3
    } amode_e;

    // Element size in bytes for a width code.
    function automatic logic [7:0] wcode_bytes(input logic [1:0] wc);
        return 8'd1 << wc;
    endfunction
endpackage

// File: rtl/vag_ctrl.sv
// Operation control: accepts start when idle, captures count, mode and width,
// counts accepted elements and pulses done after the last one.
// Assumes fire is only high while busy.
module vag_ctrl
    import vag_pkg::*;
#(
    parameter int VL_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            fire,
    input  logic [VL_W-1:0] vlen,
    input  logic [1:0]      mode_in,
    input  logic [1:0]      width_in,
    output logic            busy,
    output logic            launch,
    output logic            done,
    output logic [VL_W-1:0] elem,
    output amode_e          mode_q,
    output logic [1:0]      width_q
);
    logic [VL_W-1:0] vl_q;
    logic [VL_W-1:0] cnt_nxt;

    // Start is honoured only between operations.
    assign launch  = start && !busy;
    assign cnt_nxt = elem + 1'b1;

    // Operation state, element counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            elem    <= '0;
            vl_q    <= '0;
            mode_q  <= AM_UNIT;
            width_q <= '0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                elem    <= '0;
                vl_q    <= vlen;
                mode_q  <= amode_e'(mode_in);
                width_q <= width_in;
                if (vlen == '0) begin
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end else if (fire) begin
                elem <= cnt_nxt;
                if (cnt_nxt == vl_q) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vag_addr_acc.sv
// Running address for contiguous and strided modes: loads the base at launch
// and adds a fixed step on every accepted request. Also holds the base for
// the indexed path. Arithmetic wraps modulo 2^ADDR_W.
module vag_addr_acc
    import vag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              fire,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] stride_in,
    input  logic [1:0]        mode_in,
    input  logic [1:0]        width_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] base_q
);
    logic [ADDR_W-1:0] step_q;

    // Capture base and step at launch, advance on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            base_q   <= '0;
            step_q   <= '0;
        end else if (launch) begin
            cur_addr <= base_in;
            base_q   <= base_in;
            step_q   <= (amode_e'(mode_in) == AM_STRIDE) ? stride_in
                                                         : ADDR_W'(wcode_bytes(width_in));
        end else if (fire) begin
            cur_addr <= cur_addr + step_q;
        end
    end
endmodule

// File: rtl/vag_req_port.sv
// Request-side steering: picks the address source by mode, gates request
// valid on index availability in indexed mode, and returns index ready.
// Purely combinational.
module vag_req_port
    import vag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              busy,
    input  amode_e            mode_q,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] base_q,
    input  logic              idx_valid,
    input  logic [ADDR_W-1:0] idx_data,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              idx_ready
);
    logic is_idx;

    // Valid, address and index handshake for the current element.
    always_comb begin
        is_idx    = (mode_q == AM_INDEX);
        req_valid = busy && (!is_idx || idx_valid);
        req_addr  = is_idx ? (base_q + idx_data) : cur_addr;
        idx_ready = busy && is_idx && req_ready;
    end
endmodule

// File: rtl/vec_addr_gen.sv
// Vector memory address sequencer top. One request per element in ascending
// order, three addressing modes, one request per clock when unstalled.
// Assumes the index source holds idx_data while idx_valid is high and unaccepted.
module vec_addr_gen
    import vag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MAX_VL = 64,
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [1:0]        width,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic [VL_W-1:0]   vlen,
    input  logic              idx_valid,
    input  logic [ADDR_W-1:0] idx_data,
    output logic              idx_ready,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [1:0]        req_size,
    output logic [VL_W-1:0]   req_elem,
    output logic              done
);
    logic              busy;
    logic              launch;
    logic              fire;
    amode_e            mode_q;
    logic [1:0]        width_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] base_q;

    assign fire     = req_valid && req_ready;
    assign req_size = width_q;

    vag_ctrl #(.VL_W(VL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .fire     (fire),
        .vlen     (vlen),
        .mode_in  (mode),
        .width_in (width),
        .busy     (busy),
        .launch   (launch),
        .done     (done),
        .elem     (req_elem),
        .mode_q   (mode_q),
        .width_q  (width_q)
    );

    vag_addr_acc #(.ADDR_W(ADDR_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .fire      (fire),
        .base_in   (base_addr),
        .stride_in (stride),
        .mode_in   (mode),
        .width_in  (width),
        .cur_addr  (cur_addr),
        .base_q    (base_q)
    );

    vag_req_port #(.ADDR_W(ADDR_W)) u_port (
        .busy      (busy),
        .mode_q    (mode_q),
        .cur_addr  (cur_addr),
        .base_q    (base_q),
        .idx_valid (idx_valid),
        .idx_data  (idx_data),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .idx_ready (idx_ready)
    );
endmodule

// File: rtl/vag_checker.sv
// Protocol and ordering properties for the address sequencer, bound to the top.
module vag_checker #(
    parameter int ADDR_W = 32,
    parameter int VL_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [VL_W-1:0]   vlen,
    input logic              busy,
    input logic [1:0]        mode_q,
    input logic              idx_valid,
    input logic              idx_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [VL_W-1:0]   req_elem,
    input logic              done
);
    // R6: a stalled contiguous or strided request holds still.
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && mode_q != 2'd2
        |=> req_valid && $stable(req_addr) && $stable(req_elem));

    // R4: element numbers step by one between accepted requests.
    a_r4_elem_step: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready
        |=> !req_valid || req_elem == VL_W'($past(req_elem) + 1'b1));

    // R9: no indexed request without an index.
    a_r9_need_index: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mode_q == 2'd2 |-> idx_valid);

    // R3: an index is taken exactly with its request.
    a_r3_index_take: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid && idx_ready |-> req_valid && req_ready);

    a_r3_index_sync: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && mode_q == 2'd2 |-> idx_ready);

    // R7: zero count gives done next cycle and no request.
    a_r7_empty_vec: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && vlen == '0 |=> done && !req_valid);

    // R8: done is a single-cycle pulse unless a new empty operation starts.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);

    // R10: a start during an operation leaves the captured mode alone.
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        start && busy |=> $stable(mode_q));
endmodule

bind vec_addr_gen vag_checker #(.ADDR_W(ADDR_W), .VL_W(VL_W)) u_vag_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vlen      (vlen),
    .busy      (busy),
    .mode_q    (mode_q),
    .idx_valid (idx_valid),
    .idx_ready (idx_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_elem  (req_elem),
    .done      (done)
);

// File: tb/vec_addr_gen_test.sv
// Scoreboard bench: the driver task queues expected requests, the monitor
// pops and compares them as requests are accepted.
module vec_addr_gen_test;
    localparam int ADDR_W = 32;
    localparam int MAX_VL = 64;
    localparam int VL_W   = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic [1:0]        width = 2'd0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [ADDR_W-1:0] stride = '0;
    logic [VL_W-1:0]   vlen = '0;
    logic              idx_valid = 1'b0;
    logic [ADDR_W-1:0] idx_data = '0;
    logic              idx_ready;
    logic              req_valid;
    logic              req_ready = 1'b1;
    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        req_size;
    logic [VL_W-1:0]   req_elem;
    logic              done;

    vec_addr_gen #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .width(width),
        .base_addr(base_addr), .stride(stride), .vlen(vlen),
        .idx_valid(idx_valid), .idx_data(idx_data), .idx_ready(idx_ready),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_elem(req_elem), .done(done)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        int                elem;
        string             tag;
    } exp_t;

    exp_t              exp_q[$];
    logic [ADDR_W-1:0] idx_q[$];
    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  pending = 0;
    int  exp_done = -1;
    int  done_cyc = -1;
    bit  done_seen = 1'b0;
    bit  bp_en = 1'b0;
    bit  gap_en = 1'b0;
    int  cur_mode = 0;
    bit  hold_prev = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [VL_W-1:0]   prev_elem = '0;

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Memory-side ready pattern.
    initial forever begin
        @(posedge clk); #1;
        req_ready = bp_en ? (cyc % 3 != 0) : 1'b1;
    end

    // Index source: presents queued indices, holds them until taken.
    initial forever begin
        bit take;
        @(negedge clk);
        take = idx_valid && idx_ready;
        @(posedge clk); #1;
        if (take) idx_valid = 1'b0;
        if (!idx_valid && idx_q.size() > 0 && !(gap_en && (cyc % 4 == 1))) begin
            idx_data  = idx_q.pop_front();
            idx_valid = 1'b1;
        end
    end

    // Monitor: scoreboard compare, stall hold, index gating, done timing.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_prev) begin
                checks++;
                if (!(req_valid && req_addr == prev_addr && req_elem == prev_elem)) begin
                    errors++;
                    $display("FAIL R6 stall hold: actual v=%0b a=%h e=%0d expected v=1 a=%h e=%0d",
                             req_valid, req_addr, req_elem, prev_addr, prev_elem);
                end
            end
            hold_prev = req_valid && !req_ready;
            prev_addr = req_addr;
            prev_elem = req_elem;
            if (cur_mode == 2 && pending > 0 && !idx_valid) begin
                checks++;
                if (req_valid) begin
                    errors++;
                    $display("FAIL R9 request without index: actual valid=1 expected valid=0");
                end
            end
            if (req_valid && req_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R4 R7 unexpected request: actual addr=%h elem=%0d expected none",
                             req_addr, req_elem);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (req_addr !== e.addr || req_size !== e.size || int'(req_elem) != e.elem) begin
                        errors++;
                        $display("FAIL %s R4 R5: actual addr=%h size=%0d elem=%0d expected addr=%h size=%0d elem=%0d",
                                 e.tag, req_addr, req_size, req_elem, e.addr, e.size, e.elem);
                    end
                    pending--;
                    if (pending == 0) exp_done = cyc + 1;
                end
            end
            if (done) begin
                checks++;
                done_seen = 1'b1;
                done_cyc  = cyc;
                if (cyc != exp_done) begin
                    errors++;
                    $display("FAIL R8 done timing: actual cycle %0d expected cycle %0d", cyc, exp_done);
                end
            end
        end
    end

    // Driver: queue expectations, pulse start, wait for done.
    task automatic run_vec(input int md, input int w, input logic [ADDR_W-1:0] base,
                           input logic [ADDR_W-1:0] str, input int vl, input bit bp,
                           input bit gap, input bit mid, input string tag);
        int sc;
        int t;
        for (int i = 0; i < vl; i++) begin
            exp_t e;
            logic [ADDR_W-1:0] ix;
            ix = ADDR_W'(i * 24 + ((i % 2 == 1) ? 1000 : 0) - ((i % 3 == 2) ? 5000 : 0));
            if (md == 2) begin
                idx_q.push_back(ix);
                e.addr = base + ix;
            end else if (md == 1) begin
                e.addr = base + ADDR_W'(i) * str;
            end else begin
                e.addr = base + ADDR_W'(i << w);
            end
            e.size = 2'(w);
            e.elem = i;
            e.tag  = tag;
            exp_q.push_back(e);
        end
        pending   = vl;
        cur_mode  = md;
        bp_en     = bp;
        gap_en    = gap;
        done_seen = 1'b0;
        exp_done  = -1;
        @(posedge clk); #1;
        start = 1'b1; mode = 2'(md); width = 2'(w);
        base_addr = base; stride = str; vlen = VL_W'(vl);
        sc = cyc;
        if (vl == 0) exp_done = sc + 1;
        @(posedge clk); #1;
        start = 1'b0;
        if (mid) begin
            @(posedge clk); #1;
            start = 1'b1; base_addr = 32'hDEAD_0000; vlen = 3; mode = 2'((md + 1) % 3); width = 2'd3;
            @(posedge clk); #1;
            start = 1'b0;
        end
        t = 0;
        while (!done_seen && t < 3000) begin
            @(posedge clk); t++;
        end
        checks++;
        if (!done_seen) begin
            errors++;
            $display("FAIL %s R8 done missing: actual none expected pulse", tag);
        end
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s R4 request count: actual %0d missing expected 0 missing", tag, exp_q.size());
            exp_q.delete();
        end
        if (!bp && !gap) begin
            checks++;
            if (done_cyc != sc + vl + 1) begin
                errors++;
                $display("FAIL %s R11 throughput: actual done cycle %0d expected %0d", tag, done_cyc, sc + vl + 1);
            end
        end
        bp_en = 1'b0; gap_en = 1'b0; pending = 0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (req_valid !== 1'b0 || done !== 1'b0 || idx_ready !== 1'b0) begin
            errors++;
            $display("FAIL R4 reset state: actual v=%b d=%b ir=%b expected 0 0 0", req_valid, done, idx_ready);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        run_vec(0, 2, 32'h0000_1000, 0, 8, 0, 0, 0, "R1");
        run_vec(0, 0, 32'h0000_2003, 0, 5, 0, 0, 0, "R1");
        run_vec(3, 1, 32'h0000_3000, 0, 4, 0, 0, 0, "R1");
        run_vec(0, 3, 32'hFFFF_FFF0, 0, 4, 0, 0, 0, "R1");
        run_vec(1, 1, 32'h0000_4000, 32'd12, 6, 0, 0, 0, "R2");
        run_vec(1, 3, 32'h0000_5000, -32'sd8, 5, 0, 0, 0, "R2");
        run_vec(1, 2, 32'h0000_6000, 0, 4, 0, 0, 0, "R2");
        run_vec(1, 0, 32'h0000_7000, 32'd3, 7, 1, 0, 0, "R6");
        run_vec(2, 2, 32'h0001_0000, 0, 6, 0, 0, 0, "R3");
        run_vec(2, 1, 32'h0002_0000, 0, 9, 1, 1, 0, "R9");
        run_vec(0, 2, 32'h0000_8000, 0, 10, 1, 0, 0, "R6");
        run_vec(0, 1, 32'h0000_9000, 0, 0, 0, 0, 0, "R7");
        run_vec(2, 0, 32'h0000_A000, 0, 0, 0, 0, 0, "R7");
        run_vec(0, 0, 32'h0000_B000, 0, 64, 0, 0, 0, "R4");
        run_vec(1, 2, 32'h0000_C000, 32'd16, 6, 0, 0, 1, "R10");
        run_vec(2, 3, 32'h0000_D000, 0, 5, 0, 0, 1, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule